// File: doc/BRIEF.md
# WLAN Receive Header Classifier

This block watches the opening bytes of a received 802.11 MPDU and turns them into a compact receive status. Bytes arrive one per accepted cycle on an 8-bit stream. The stream carries a valid qualifier and strobes that mark the first and the last byte. The block decodes the frame control field. It takes the group bit of the receiver address, the full BSSID (address 3), the fragment number from sequence control and, for QoS data frames, the end-of-service-period bit. It then pulses a ready strobe together with a 6-bit frame-group code and a 32-bit flag word.

The frame-group code sorts each frame into one class, chosen by priority. An externally detected null-data-packet condition wins over everything. Unsupported protocol versions or frame types come next. Data frames are split into multicast, unicast and null. Management and control frames are folded into two contiguous code ranges indexed by subtype. Multicast is recognised only when the BSSID of the frame equals one of four BSSID registers that carry a valid bit. These registers are loaded through a small write port. Header flags are reported only when the frame is marked as carrying the first MSDU.

Top module: `rxhdr_classifier`

## Requirements
- R1: While reset is asserted and in the cycles after its release, before any frame, `stat_ready` is 0.
- R2: Byte positions count from 0 at the byte with `in_sof`: frame control 0..1, receiver address 4..9 (group bit = bit 0 of byte 4), BSSID 16..21 with byte 16 as the least significant, sequence control 22..23, QoS control 24..25. `stat_ready` is high for exactly one cycle, in the cycle after the deciding byte is accepted. The deciding byte is byte 25 for QoS data frames, byte 23 for all others, or the `in_eof` byte if that comes earlier. Later bytes, up to the next `in_sof`, change neither the pulse nor the reported status.
- R3: For a data frame (type 2, version 0, no NDP), the group is 1 when the multicast condition of R8 holds. Otherwise it is 3 for subtypes 4 and 12 (null and QoS null), and 2 for every other subtype.
- R4: A management frame (type 0, version 0) gets group 4 + subtype, which gives codes 4..19.
- R5: A control frame (type 1, version 0) gets group 20 + subtype, which gives codes 20..35.
- R6: A frame with a protocol version other than 0 (frame control byte 0 bits 1:0), or with type 3 (bits 3:2), gets group 36 unless R7 applies.
- R7: If `ndp_strobe` is high in any cycle from the start byte through the deciding byte, the group is 0, ahead of every other rule except R13. A strobe that comes after the deciding byte has no effect.
- R8: Multicast holds when the receiver-address group bit is 1 and the BSSID equals a register whose valid bit is set. A write with `cfg_we` loads register `cfg_sel` with `cfg_bssid` and `cfg_valid`. A register with its valid bit cleared never matches. Flag word bit 2 reports multicast.
- R9: Flag word bit 13 is set when more-fragments (byte 1 bit 2) is 1 or the fragment number (byte 22 bits 3:0) is not zero.
- R10: Flag word bit 11 is bit 4 of byte 24, and only for data frames whose subtype bit 3 is set. Otherwise it is 0.
- R11: Further flag word bits are: bit 5 power management (byte 1 bit 4), bit 10 more data (byte 1 bit 5), bit 14 order (byte 1 bit 7), bit 8 type 0, bit 9 type 1, and bit 7 null data (type 2, subtype 4 or 12). Bits 1, 3, 4, 6, 12 and 15..31 are 0.
- R12: Flag word bit 0 is the value of `in_first` sampled with the start byte. When it is 0, every other bit of the flag word is 0.
- R13: A frame whose `in_eof` byte is byte 0 reports group 36 and a flag word with all bits except bit 0 cleared. Bytes that were not received read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Byte on `in_data` is valid |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| in_data | input | 8 | Frame byte |
| in_first | input | 1 | Frame carries the first MSDU, sampled with the start byte |
| ndp_strobe | input | 1 | External null-data-packet detection |
| cfg_we | input | 1 | BSSID register write enable |
| cfg_sel | input | 2 | BSSID register index |
| cfg_bssid | input | 48 | BSSID value to write |
| cfg_valid | input | 1 | Valid bit to write |
| stat_ready | output | 1 | One-cycle status-ready pulse |
| stat_group | output | 6 | Frame-group code |
| stat_word | output | 32 | Flag word |

## Verification
The hardest case to reach from the ports is the race between the deciding byte and its neighbours. A frame can end early by `in_eof` in any position. A QoS data frame moves the deciding byte from 23 to 25. The NDP strobe can land just before or just after the deciding byte. The bench sweeps the frame length from 1 to 30 for both QoS and plain data. It places the NDP strobe at the start byte, inside the header, and after the decision. It keeps driving random bytes past the decision and then confirms that the reported status has not moved. The multicast gate is reached by pointing the BSSID at each register in turn, including one held invalid, and by clearing a valid bit between frames.

// File: rtl/rxhdr_pkg.sv
package rxhdr_pkg;

  localparam int unsigned ADDR_W = 48;
  localparam int unsigned GRP_W  = 6;

  // byte positions within a frame
  localparam int unsigned POS_FC0      = 0;
  localparam int unsigned POS_FC1      = 1;
  localparam int unsigned POS_RA0      = 4;
  localparam int unsigned POS_BSS0     = 16;
  localparam int unsigned POS_SEQ0     = 22;
  localparam int unsigned POS_END_PLAIN = 23;
  localparam int unsigned POS_QOS0     = 24;
  localparam int unsigned POS_END_QOS  = 25;
  localparam int unsigned ADDR_BYTES   = ADDR_W / 8;

  // group codes
  localparam logic [GRP_W-1:0] GRP_NDP       = 6'd0;
  localparam logic [GRP_W-1:0] GRP_MCAST     = 6'd1;
  localparam logic [GRP_W-1:0] GRP_UCAST     = 6'd2;
  localparam logic [GRP_W-1:0] GRP_NULL      = 6'd3;
  localparam logic [GRP_W-1:0] GRP_MGMT_BASE = 6'd4;
  localparam logic [GRP_W-1:0] GRP_CTRL_BASE = 6'd20;
  localparam logic [GRP_W-1:0] GRP_UNSUP     = 6'd36;

  // flag word bit positions
  localparam int unsigned FB_FIRST = 0;
  localparam int unsigned FB_MCAST = 2;
  localparam int unsigned FB_PM    = 5;
  localparam int unsigned FB_NULL  = 7;
  localparam int unsigned FB_MGMT  = 8;
  localparam int unsigned FB_CTRL  = 9;
  localparam int unsigned FB_MORE  = 10;
  localparam int unsigned FB_EOSP  = 11;
  localparam int unsigned FB_FRAG  = 13;
  localparam int unsigned FB_ORDER = 14;

  typedef struct packed {
    logic              fc_ok;
    logic              first;
    logic              ndp;
    logic [7:0]        fc0;
    logic              mfrag;
    logic              pm;
    logic              more;
    logic              order;
    logic              ra_group;
    logic [ADDR_W-1:0] bssid;
    logic [3:0]        fragno;
    logic              eosp_bit;
  } hdr_t;

  function automatic logic has_qos(input logic [7:0] fc0);
    return (fc0[3:2] == 2'b10) && fc0[7];
  endfunction

endpackage

// File: rtl/rxhdr_bssid_bank.sv
module rxhdr_bssid_bank
  import rxhdr_pkg::*;
#(
  parameter int NUM   = 4,
  localparam int SEL_W = (NUM > 1) ? $clog2(NUM) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [ADDR_W-1:0] cfg_bssid,
  input  logic              cfg_valid,
  input  logic [ADDR_W-1:0] cmp_bssid,
  output logic [NUM-1:0]    hit
);

  for (genvar g = 0; g < NUM; g++) begin : g_ent
    logic [ADDR_W-1:0] addr_q, addr_d;
    logic              vld_q, vld_d;
    logic              wr_en;

    always_comb begin
      wr_en  = cfg_we && (cfg_sel == SEL_W'(g));
      addr_d = wr_en ? cfg_bssid : addr_q;
      vld_d  = wr_en ? cfg_valid : vld_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        addr_q <= '0;
        vld_q  <= 1'b0;
      end else if (wr_en) begin
        addr_q <= addr_d;
        vld_q  <= vld_d;
      end
    end

    assign hit[g] = vld_q && (addr_q == cmp_bssid);
  end

endmodule

// File: rtl/rxhdr_capture.sv
module rxhdr_capture
  import rxhdr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic       in_sof,
  input  logic       in_eof,
  input  logic [7:0] in_data,
  input  logic       in_first,
  input  logic       ndp_in,
  output hdr_t       hdr,
  output logic       done
);

  localparam int CNT_W = $clog2(POS_END_QOS + 2);
  localparam logic [CNT_W-1:0] P_FC0  = CNT_W'(POS_FC0);
  localparam logic [CNT_W-1:0] P_FC1  = CNT_W'(POS_FC1);
  localparam logic [CNT_W-1:0] P_RA0  = CNT_W'(POS_RA0);
  localparam logic [CNT_W-1:0] P_SEQ0 = CNT_W'(POS_SEQ0);
  localparam logic [CNT_W-1:0] P_QOS0 = CNT_W'(POS_QOS0);
  localparam logic [CNT_W-1:0] P_ENDP = CNT_W'(POS_END_PLAIN);
  localparam logic [CNT_W-1:0] P_ENDQ = CNT_W'(POS_END_QOS);

  logic [CNT_W-1:0] cnt_q, cnt_d, idx;
  logic             active_q, active_d;
  logic             done_q, done_d;
  hdr_t             hdr_q, hdr_d;
  logic             accept, last;

  always_comb begin
    accept   = in_valid && (in_sof || active_q);
    idx      = in_sof ? '0 : cnt_q;
    hdr_d    = hdr_q;
    cnt_d    = cnt_q;
    active_d = active_q;
    done_d   = 1'b0;
    last     = 1'b0;

    if (active_q && ndp_in) hdr_d.ndp = 1'b1;

    if (accept) begin
      if (in_sof) begin
        hdr_d       = '0;
        hdr_d.first = in_first;
        hdr_d.ndp   = ndp_in;
      end
      if (idx == P_FC0) hdr_d.fc0 = in_data;
      if (idx == P_FC1) begin
        hdr_d.fc_ok = 1'b1;
        hdr_d.mfrag = in_data[2];
        hdr_d.pm    = in_data[4];
        hdr_d.more  = in_data[5];
        hdr_d.order = in_data[7];
      end
      if (idx == P_RA0) hdr_d.ra_group = in_data[0];
      for (int k = 0; k < ADDR_BYTES; k++) begin
        if (idx == CNT_W'(POS_BSS0 + k)) hdr_d.bssid[8*k +: 8] = in_data;
      end
      if (idx == P_SEQ0) hdr_d.fragno = in_data[3:0];
      if (idx == P_QOS0) hdr_d.eosp_bit = in_data[4];

      last = in_eof || (idx == P_ENDQ) ||
             ((idx == P_ENDP) && !has_qos(hdr_d.fc0));
      cnt_d    = idx + 1'b1;
      active_d = !last;
      done_d   = last;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
      done_q   <= 1'b0;
      hdr_q    <= '0;
    end else begin
      done_q <= done_d;
      if (accept) begin
        cnt_q    <= cnt_d;
        active_q <= active_d;
      end
      if (accept || active_q) hdr_q <= hdr_d;
    end
  end

  assign hdr  = hdr_q;
  assign done = done_q;

endmodule

// File: rtl/rxhdr_classify.sv
module rxhdr_classify
  import rxhdr_pkg::*;
(
  input  hdr_t             hdr,
  input  logic             bss_hit,
  output logic [GRP_W-1:0] group,
  output logic [31:0]      flags
);

  logic [1:0] ver, ftype;
  logic [3:0] sub;
  logic       mcast, is_null, eosp, frag;

  always_comb begin
    ver     = hdr.fc0[1:0];
    ftype   = hdr.fc0[3:2];
    sub     = hdr.fc0[7:4];
    mcast   = hdr.ra_group && bss_hit;
    is_null = (ftype == 2'b10) && ((sub == 4'd4) || (sub == 4'd12));
    eosp    = has_qos(hdr.fc0) && hdr.eosp_bit;
    frag    = hdr.mfrag || (hdr.fragno != 4'd0);

    if (!hdr.fc_ok)                       group = GRP_UNSUP;
    else if (hdr.ndp)                     group = GRP_NDP;
    else if (ver != 2'd0 || ftype == 2'd3) group = GRP_UNSUP;
    else if (ftype == 2'd0)               group = GRP_MGMT_BASE + {2'b00, sub};
    else if (ftype == 2'd1)               group = GRP_CTRL_BASE + {2'b00, sub};
    else if (mcast)                       group = GRP_MCAST;
    else if (is_null)                     group = GRP_NULL;
    else                                  group = GRP_UCAST;

    flags = '0;
    flags[FB_FIRST] = hdr.first;
    if (hdr.fc_ok && hdr.first) begin
      flags[FB_MCAST] = mcast;
      flags[FB_PM]    = hdr.pm;
      flags[FB_NULL]  = is_null;
      flags[FB_MGMT]  = (ftype == 2'd0);
      flags[FB_CTRL]  = (ftype == 2'd1);
      flags[FB_MORE]  = hdr.more;
      flags[FB_EOSP]  = eosp;
      flags[FB_FRAG]  = frag;
      flags[FB_ORDER] = hdr.order;
    end
  end

endmodule

// File: rtl/rxhdr_classifier.sv
module rxhdr_classifier
  import rxhdr_pkg::*;
#(
  parameter int NUM_BSSID = 4,
  localparam int SEL_W = (NUM_BSSID > 1) ? $clog2(NUM_BSSID) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic [7:0]       in_data,
  input  logic             in_first,
  input  logic             ndp_strobe,
  input  logic             cfg_we,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic [47:0]      cfg_bssid,
  input  logic             cfg_valid,
  output logic             stat_ready,
  output logic [5:0]       stat_group,
  output logic [31:0]      stat_word
);

  logic [1:0]           rst_pipe_q;
  logic                 rst_n_int;
  hdr_t                 hdr;
  logic [NUM_BSSID-1:0] hit;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_int = rst_pipe_q[1];

  rxhdr_capture i_capture (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .in_valid (in_valid),
    .in_sof   (in_sof),
    .in_eof   (in_eof),
    .in_data  (in_data),
    .in_first (in_first),
    .ndp_in   (ndp_strobe),
    .hdr      (hdr),
    .done     (stat_ready)
  );

  rxhdr_bssid_bank #(.NUM(NUM_BSSID)) i_bank (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_bssid (cfg_bssid),
    .cfg_valid (cfg_valid),
    .cmp_bssid (hdr.bssid),
    .hit       (hit)
  );

  rxhdr_classify i_classify (
    .hdr     (hdr),
    .bss_hit (|hit),
    .group   (stat_group),
    .flags   (stat_word)
  );

endmodule

// File: rtl/rxhdr_checker.sv
module rxhdr_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        stat_ready,
  input logic [5:0]  stat_group,
  input logic [31:0] stat_word
);

  // R2: a ready pulse always follows an accepted byte
  a_r2_ready_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
    stat_ready |-> $past(in_valid));

  // R6: no code above the unsupported code is ever produced
  a_r6_group_range: assert property (@(posedge clk) disable iff (!rst_n)
    stat_ready |-> (stat_group <= 6'd36));

  // R12: a non-first frame reports no header flags
  a_r12_first_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_ready && !stat_word[0]) |-> (stat_word[31:1] == 31'd0));

  // R11: unused flag positions stay zero
  a_r11_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    stat_ready |-> (stat_word[31:15] == 17'd0 && !stat_word[12] && !stat_word[6] &&
                    stat_word[4:3] == 2'b00 && !stat_word[1]));

  // R11: management, control and null-data flags exclude each other
  a_r11_type_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    stat_ready |-> $onehot0({stat_word[7], stat_word[8], stat_word[9]}));

  // R4: management flag only with a management code (or NDP/unsupported)
  a_r4_mgmt_range: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_ready && stat_word[8]) |->
      (stat_group == 6'd0 || stat_group == 6'd36 ||
       (stat_group >= 6'd4 && stat_group <= 6'd19)));

  // R5: control flag only with a control code (or NDP/unsupported)
  a_r5_ctrl_range: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_ready && stat_word[9]) |->
      (stat_group == 6'd0 || stat_group == 6'd36 ||
       (stat_group >= 6'd20 && stat_group <= 6'd35)));

  // R3: null-data flag only with null, multicast, NDP or unsupported codes
  a_r3_null_group: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_ready && stat_word[7]) |->
      (stat_group == 6'd0 || stat_group == 6'd1 ||
       stat_group == 6'd3 || stat_group == 6'd36));

  // R10: end-of-service-period only for data frames
  a_r10_eosp_data: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_ready && stat_word[11]) |-> (!stat_word[8] && !stat_word[9]));

endmodule

bind rxhdr_classifier rxhdr_checker i_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .stat_ready (stat_ready),
  .stat_group (stat_group),
  .stat_word  (stat_word)
);

// File: tb/test_rxhdr_classifier.sv
module test_rxhdr_classifier;

  logic        clk;
  logic        rst_n;
  logic        in_valid, in_sof, in_eof, in_first, ndp_strobe;
  logic [7:0]  in_data;
  logic        cfg_we, cfg_valid;
  logic [1:0]  cfg_sel;
  logic [47:0] cfg_bssid;
  logic        stat_ready;
  logic [5:0]  stat_group;
  logic [31:0] stat_word;

  int errors = 0;
  int checks = 0;

  logic [7:0]  fb [0:31];
  int          flen;
  logic        f_first;
  int          ndp_at;
  logic [47:0] m_bss [0:3];
  logic        m_vld [0:3];

  rxhdr_classifier i_rxhdr_classifier (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_eof(in_eof), .in_data(in_data), .in_first(in_first),
    .ndp_strobe(ndp_strobe), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_bssid(cfg_bssid), .cfg_valid(cfg_valid), .stat_ready(stat_ready),
    .stat_group(stat_group), .stat_word(stat_word)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic cfg_write(input int sel, input logic [47:0] a, input logic v);
    cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_bssid = a; cfg_valid = v;
    @(negedge clk);
    cfg_we = 1'b0;
    m_bss[sel] = a;
    m_vld[sel] = v;
  endtask

  task automatic build(input logic [7:0] fc0, input logic [7:0] fc1,
                       input logic g, input logic [47:0] bss,
                       input logic [7:0] seq0, input logic [7:0] qos0);
    for (int k = 0; k < 32; k++) fb[k] = 8'($urandom);
    fb[0] = fc0;
    fb[1] = fc1;
    fb[4] = {fb[4][7:1], g};
    for (int k = 0; k < 6; k++) fb[16+k] = bss[8*k +: 8];
    fb[22] = seq0;
    fb[24] = qos0;
  endtask

  function automatic logic [7:0] got(input int k, input int ridx);
    return (k <= ridx) ? fb[k] : 8'h00;
  endfunction

  task automatic run_frame(input string tag);
    logic [7:0]  fc0, fc1;
    logic [1:0]  ver, ty;
    logic [3:0]  sub;
    logic        qos, fcok, hit, mc, ndp, isnull;
    logic [47:0] a3;
    int          dec, ridx, egrp, rcnt, r_idx;
    logic [31:0] eword, r_word;
    logic [5:0]  r_grp;

    fc0  = fb[0];
    ver  = fc0[1:0];
    ty   = fc0[3:2];
    sub  = fc0[7:4];
    qos  = (ty == 2'd2) && sub[3];
    dec  = qos ? 25 : 23;
    ridx = (flen - 1 < dec) ? flen - 1 : dec;
    fcok = (ridx >= 1);
    fc1  = got(1, ridx);
    for (int k = 0; k < 6; k++) a3[8*k +: 8] = got(16 + k, ridx);
    hit = 1'b0;
    for (int k = 0; k < 4; k++) if (m_vld[k] && m_bss[k] == a3) hit = 1'b1;
    mc     = got(4, ridx)[0] && hit;
    ndp    = (ndp_at >= 0) && (ndp_at <= ridx);
    isnull = (ty == 2'd2) && (sub == 4'd4 || sub == 4'd12);

    if (!fcok)                           egrp = 36;
    else if (ndp)                        egrp = 0;
    else if (ver != 2'd0 || ty == 2'd3)  egrp = 36;
    else if (ty == 2'd0)                 egrp = 4 + int'(sub);
    else if (ty == 2'd1)                 egrp = 20 + int'(sub);
    else if (mc)                         egrp = 1;
    else if (isnull)                     egrp = 3;
    else                                 egrp = 2;

    eword = 32'd0;
    eword[0] = f_first;
    if (fcok && f_first) begin
      eword[2]  = mc;
      eword[5]  = fc1[4];
      eword[7]  = isnull;
      eword[8]  = (ty == 2'd0);
      eword[9]  = (ty == 2'd1);
      eword[10] = fc1[5];
      eword[11] = qos && got(24, ridx)[4];
      eword[13] = fc1[2] || (got(22, ridx)[3:0] != 4'd0);
      eword[14] = fc1[7];
    end

    rcnt = 0; r_idx = -1; r_word = '0; r_grp = '0;
    for (int i = 0; i < flen; i++) begin
      in_valid   = 1'b1;
      in_sof     = (i == 0);
      in_eof     = (i == flen - 1);
      in_data    = fb[i];
      in_first   = (i == 0) ? f_first : ~f_first;
      ndp_strobe = (i == ndp_at);
      @(negedge clk);
      if (stat_ready) begin
        rcnt++; r_idx = i; r_grp = stat_group; r_word = stat_word;
      end
    end
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; ndp_strobe = 1'b0;
    @(negedge clk);
    if (stat_ready) rcnt++;

    check("R2", "ready pulse count", 32'(rcnt), 32'd1);
    check("R2", "ready position", 32'(r_idx), 32'(ridx));
    check(tag, "group", 32'(r_grp), 32'(egrp));
    check(tag, "flag word", r_word, eword);
    // R2: trailing bytes must not have disturbed the held status
    check("R2", "held group", 32'(stat_group), 32'(egrp));
    check("R2", "held word", stat_word, eword);
  endtask

  function automatic logic [47:0] pick_bss(input int sel);
    return (sel < 4) ? m_bss[sel] : {16'hFACE, 32'($urandom)};
  endfunction

  initial begin
    int steps = 0;
    while (steps < 150000) begin
      @(posedge clk);
      steps++;
    end
    checks++;
    errors++;
    $display("FAIL R2 watchdog expired actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    in_data = '0; in_first = 1'b0; ndp_strobe = 1'b0;
    cfg_we = 1'b0; cfg_sel = '0; cfg_bssid = '0; cfg_valid = 1'b0;
    for (int k = 0; k < 4; k++) begin m_bss[k] = '0; m_vld[k] = 1'b0; end
    ndp_at = -1; f_first = 1'b1; flen = 30;

    repeat (3) @(negedge clk);
    check("R1", "ready in reset", 32'(stat_ready), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", "ready after reset", 32'(stat_ready), 32'd0);

    cfg_write(0, 48'h0A0B0C0D0E0F, 1'b1);
    cfg_write(1, 48'h112233445566, 1'b1);
    cfg_write(2, 48'hFFEEDDCCBBAA, 1'b1);
    cfg_write(3, 48'h5A5A5A5A5A5A, 1'b0);

    // management subtypes
    for (int s = 0; s < 16; s++) begin
      build({4'(s), 4'b0000}, 8'($urandom), 1'($urandom), pick_bss(s % 5), 8'h00, 8'h00);
      run_frame("R4");
    end
    // control subtypes
    for (int s = 0; s < 16; s++) begin
      build({4'(s), 4'b0100}, 8'($urandom), 1'($urandom), pick_bss(s % 5), 8'h00, 8'h00);
      run_frame("R5");
    end
    // data subtypes x group bit x BSSID choice
    for (int s = 0; s < 16; s++)
      for (int g = 0; g < 2; g++)
        for (int b = 0; b < 5; b++) begin
          build({4'(s), 4'b1000}, 8'($urandom), 1'(g), pick_bss(b), 8'h00, 8'($urandom));
          run_frame(g == 1 ? "R8" : (s >= 8 ? "R10" : "R3"));
        end
    // unsupported: type 3 and non-zero versions
    for (int s = 0; s < 16; s++) begin
      build({4'(s), 4'b1100}, 8'($urandom), 1'b1, m_bss[0], 8'h00, 8'h00);
      run_frame("R6");
    end
    for (int v = 1; v < 4; v++)
      for (int t = 0; t < 3; t++) begin
        build({4'd0, 2'(t), 2'(v)}, 8'h00, 1'b1, m_bss[1], 8'h00, 8'h00);
        run_frame("R6");
      end
    // NDP strobe position
    foreach (fb[k]) fb[k] = fb[k];
    for (int p = 0; p < 6; p++) begin
      build(8'h08, 8'($urandom), 1'b1, m_bss[0], 8'h00, 8'h00);
      ndp_at = (p == 0) ? 0 : (p == 1) ? 5 : (p == 2) ? 22 : (p == 3) ? 23 : (p == 4) ? 24 : 28;
      run_frame("R7");
    end
    build(8'hF0, 8'h00, 1'b0, m_bss[0], 8'h00, 8'h00);
    ndp_at = 3;
    run_frame("R7");
    ndp_at = -1;
    // fragment flag
    for (int m = 0; m < 2; m++)
      for (int q = 0; q < 4; q++) begin
        build(8'h08, {5'b0, 1'(m), 2'b00}, 1'b0, m_bss[0],
              (q == 0) ? 8'h00 : (q == 1) ? 8'h01 : (q == 2) ? 8'h08 : 8'hF0, 8'h00);
        run_frame("R9");
      end
    // random frame-control flags
    for (int n = 0; n < 24; n++) begin
      build({4'($urandom), 2'(n % 3), 2'b00}, 8'($urandom), 1'($urandom),
            pick_bss(n % 5), 8'($urandom), 8'($urandom));
      run_frame("R11");
    end
    // not the first MSDU
    f_first = 1'b0;
    for (int n = 0; n < 12; n++) begin
      build({4'($urandom), 2'(n % 3), 2'b00}, 8'hFF, 1'b1, m_bss[n % 3], 8'h0F, 8'hFF);
      run_frame("R12");
    end
    f_first = 1'b1;
    // early end of frame: every length, plain and QoS data
    for (int l = 1; l <= 30; l++) begin
      flen = l;
      build(8'h88, 8'($urandom), 1'b1, m_bss[2], 8'($urandom), 8'hFF);
      run_frame(l == 1 ? "R13" : "R2");
      build(8'h08, 8'($urandom), 1'b1, m_bss[1], 8'($urandom), 8'hFF);
      run_frame(l == 1 ? "R13" : "R2");
    end
    for (int n = 0; n < 4; n++) begin
      flen = 1;
      f_first = 1'(n);
      build(8'($urandom), 8'hFF, 1'b1, m_bss[0], 8'hFF, 8'hFF);
      run_frame("R13");
    end
    flen = 30; f_first = 1'b1;
    // invalidate a register, then restore it
    cfg_write(0, 48'h0A0B0C0D0E0F, 1'b0);
    build(8'h08, 8'h00, 1'b1, 48'h0A0B0C0D0E0F, 8'h00, 8'h00);
    run_frame("R8");
    cfg_write(3, 48'h5A5A5A5A5A5A, 1'b1);
    build(8'h08, 8'h00, 1'b1, 48'h5A5A5A5A5A5A, 8'h00, 8'h00);
    run_frame("R8");
    cfg_write(0, 48'h0A0B0C0D0E0F, 1'b1);
    build(8'h08, 8'h00, 1'b1, 48'h0A0B0C0D0E0F, 8'h00, 8'h00);
    run_frame("R8");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule